// File: doc/BRIEF.md
# Accumulator Barrel Shifter

This block shifts a 40-bit accumulator value left or right by a signed amount and registers the outcome with its condition flags. A single control bit picks a logical shift, which treats the accumulator as 40 unsigned bits, or an arithmetic shift, which treats bit 39 as the sign.

The shift amount comes from one of two places. It can be a signed 8-bit immediate, where a negative value means shift right. It can also be a signed 16-bit register operand, where a positive value means shift right. The register operand is chosen from four 16-bit candidates. The sign of the amount sets the direction and its magnitude sets the distance. Distances of 40 or more saturate.

A result is captured on the clock edge where `in_valid` is high. It stays unchanged until the next valid input.

Top module: `acc_shifter`

## Requirements
- R1: While reset is low and after its release, until the first valid input, `result` is 0, `flag_z` is 1 and `flag_n`, `flag_c`, `flag_v` are 0.
- R2: A valid input updates `result` and the flags at the next rising clock edge. When `in_valid` is low, `result` and all flags hold their values.
- R3: With `use_reg`=0, `imm_amt` is read as 8-bit two's complement. A negative value shifts right by its magnitude. Zero or a positive value shifts left by that value.
- R4: With `use_reg`=1, the selected 16-bit operand is read as two's complement. A positive value shifts right by that value. Zero or a negative value shifts left by its magnitude.
- R5: `reg_src` selects the register operand: 0 picks `x_hi`, 1 picks `y_hi`, 2 picks `a_mid`, 3 picks `b_mid`.
- R6: A logical right shift (`arith`=0) fills with zeros. An arithmetic right shift (`arith`=1) fills with copies of `acc_in[39]`.
- R7: A left shift fills with zeros, drops bits above bit 39, and gives the same result for both shift kinds.
- R8: When the magnitude is 40 or more, the result is all zeros. The one exception is an arithmetic right shift, which gives 40 copies of `acc_in[39]`.
- R9: After every valid input, `flag_c` and `flag_v` are 0.
- R10: `flag_z` is 1 exactly when all 40 result bits are 0. `flag_n` equals result bit 39.
- R11: An amount of zero, in either form, passes `acc_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture a new shift result this cycle |
| acc_in | input | 40 | Accumulator operand |
| arith | input | 1 | 1 selects arithmetic shift, 0 selects logical shift |
| use_reg | input | 1 | 1 takes the amount from a register operand, 0 from the immediate |
| imm_amt | input | 8 | Signed immediate amount (negative = right) |
| reg_src | input | 2 | Register operand select |
| x_hi | input | 16 | Register candidate 0 |
| y_hi | input | 16 | Register candidate 1 |
| a_mid | input | 16 | Register candidate 2 |
| b_mid | input | 16 | Register candidate 3 |
| result | output | 40 | Registered shift result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 39 |
| flag_c | output | 1 | Carry, always cleared by a shift |
| flag_v | output | 1 | Overflow, always cleared by a shift |

## Verification
The only state is the result register and its flags. A wrong direction decode, a wrong sign convention or a wrong fill bit therefore shows on `result` in the cycle right after the offending input. A flag held out of step with the result shows in that same cycle as a mismatch between `flag_z`/`flag_n` and the 40 result bits. A faulty hold path shows as a change on an idle cycle.

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int ACC_W = 40,
  parameter int IMM_W = 8,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             arith,
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm_amt,
  input  logic [1:0]       reg_src,
  input  logic [REG_W-1:0] x_hi,
  input  logic [REG_W-1:0] y_hi,
  input  logic [REG_W-1:0] a_mid,
  input  logic [REG_W-1:0] b_mid,
  output logic [ACC_W-1:0] result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c,
  output logic             flag_v
);

  localparam int MAG_W = ((REG_W > IMM_W) ? REG_W : IMM_W) + 1;
  localparam int SH_W  = $clog2(ACC_W);

  logic [REG_W-1:0]        reg_amt;
  logic signed [MAG_W-1:0] imm_s, reg_s, dir_amt;
  logic [MAG_W-1:0]        mag;
  logic                    go_right, too_far, fill;
  logic [SH_W-1:0]         sh;
  logic [2*ACC_W-1:0]      wide_r;
  logic [ACC_W-1:0]        shifted;

  always_comb begin
    case (reg_src)
      2'd0:    reg_amt = x_hi;
      2'd1:    reg_amt = y_hi;
      2'd2:    reg_amt = a_mid;
      default: reg_amt = b_mid;
    endcase
  end

  // Normalise both forms so that a negative dir_amt means "shift right".
  assign imm_s    = {{(MAG_W-IMM_W){imm_amt[IMM_W-1]}}, imm_amt};
  assign reg_s    = {{(MAG_W-REG_W){reg_amt[REG_W-1]}}, reg_amt};
  assign dir_amt  = use_reg ? -reg_s : imm_s;
  assign go_right = dir_amt[MAG_W-1];
  assign mag      = go_right ? -dir_amt : dir_amt;
  assign too_far  = mag >= MAG_W'(ACC_W);
  assign sh       = mag[SH_W-1:0];
  assign fill     = arith & acc_in[ACC_W-1];
  assign wide_r   = {{ACC_W{fill}}, acc_in} >> sh;

  always_comb begin
    if (too_far)
      shifted = go_right ? {ACC_W{fill}} : '0;
    else if (go_right)
      shifted = wide_r[ACC_W-1:0];
    else
      shifted = acc_in << sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      flag_z <= 1'b1;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else if (in_valid) begin
      result <= shifted;
      flag_z <= (shifted == '0);
      flag_n <= shifted[ACC_W-1];
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end
  end

endmodule

module acc_shifter_chk #(
  parameter int ACC_W = 40,
  parameter int IMM_W = 8,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [ACC_W-1:0] acc_in,
  input logic             arith,
  input logic             use_reg,
  input logic [IMM_W-1:0] imm_amt,
  input logic [1:0]       reg_src,
  input logic [REG_W-1:0] x_hi,
  input logic [ACC_W-1:0] result,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_c,
  input logic             flag_v
);

  AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!flag_c && !flag_v)); // R9

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z == (result == '0)); // R10

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_n == result[ACC_W-1]); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flag_z) && $stable(flag_n))); // R2

  AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_reg && imm_amt == '0) |=> (result == $past(acc_in))); // R11

  AST_FAR_LOGICAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_reg && reg_src == 2'd0 && !arith && !x_hi[REG_W-1]
     && x_hi >= REG_W'(ACC_W)) |=> (result == '0)); // R8

endmodule

bind acc_shifter acc_shifter_chk #(.ACC_W(ACC_W), .IMM_W(IMM_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in), .arith(arith),
  .use_reg(use_reg), .imm_amt(imm_amt), .reg_src(reg_src), .x_hi(x_hi),
  .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
);

// File: tb/test_acc_shifter.sv
module test_acc_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [39:0] acc_in = '0;
  logic        arith = 1'b0;
  logic        use_reg = 1'b0;
  logic [7:0]  imm_amt = '0;
  logic [1:0]  reg_src = '0;
  logic [15:0] x_hi = '0, y_hi = '0, a_mid = '0, b_mid = '0;
  logic [39:0] result;
  logic        flag_z, flag_n, flag_c, flag_v;

  logic [39:0] exp_res = '0;
  logic        exp_z = 1'b1;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  acc_shifter i_acc_shifter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_in(acc_in), .arith(arith),
    .use_reg(use_reg), .imm_amt(imm_amt), .reg_src(reg_src), .x_hi(x_hi), .y_hi(y_hi),
    .a_mid(a_mid), .b_mid(b_mid), .result(result), .flag_z(flag_z), .flag_n(flag_n),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic logic [39:0] model(input logic [39:0] acc, input logic ar,
      input logic ur, input logic [7:0] imm, input logic [1:0] src,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] a, input logic [15:0] b);
    int     amt, mag;
    bit     right;
    longint op, res;
    logic [15:0] rv;
    if (!ur) begin
      amt = $signed(imm);
      right = amt < 0;
      mag = right ? -amt : amt;
    end else begin
      rv = (src == 0) ? x : (src == 1) ? y : (src == 2) ? a : b;
      amt = $signed(rv);
      right = amt > 0;
      mag = right ? amt : -amt;
    end
    if (mag > 63) mag = 63;
    op = ar ? longint'($signed({{24{acc[39]}}, acc})) : longint'({24'd0, acc});
    if (right) res = ar ? (op >>> mag) : (op >> mag);
    else       res = op << mag;
    return res[39:0];
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (result !== exp_res || flag_z !== exp_z || flag_n !== exp_res[39] ||
        flag_c !== 1'b0 || flag_v !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: got res=%h z=%b n=%b c=%b v=%b, expected res=%h z=%b n=%b c=0 v=0",
               tag, result, flag_z, flag_n, flag_c, flag_v, exp_res, exp_z, exp_res[39]);
    end
  endtask

  task automatic apply(input logic vld, input logic [39:0] acc, input logic ar,
      input logic ur, input logic [7:0] imm, input logic [1:0] src,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] a,
      input logic [15:0] b, input string tag);
    in_valid = vld; acc_in = acc; arith = ar; use_reg = ur; imm_amt = imm;
    reg_src = src; x_hi = x; y_hi = y; a_mid = a; b_mid = b;
    @(posedge clk);
    if (vld) begin
      exp_res = model(acc, ar, ur, imm, src, x, y, a, b);
      exp_z = (exp_res == '0);
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
    apply(1, 40'h00_0000_0001, 0, 0, 8'd4,   0, 0, 0, 0, 0, "R3 imm left");
    apply(1, 40'h80_0000_0000, 0, 0, 8'hFC,  0, 0, 0, 0, 0, "R6 logical right");
    apply(1, 40'h80_0000_0000, 1, 0, 8'hFC,  0, 0, 0, 0, 0, "R6 arith right");
    apply(1, 40'h00_0000_0100, 0, 1, 8'h00,  0, 16'd4, 0, 0, 0, "R4 reg right x");
    apply(1, 40'h00_0000_0100, 0, 1, 8'h00,  1, 0, 16'hFFFC, 0, 0, "R4 R5 reg left y");
    apply(1, 40'h00_0000_0100, 1, 1, 8'h00,  2, 0, 0, 16'd8, 16'd1, "R5 a_mid");
    apply(1, 40'h00_0000_0100, 1, 1, 8'h00,  3, 0, 0, 16'd8, 16'd1, "R5 b_mid");
    apply(1, 40'hFF_0000_0001, 0, 0, 8'd8,   0, 0, 0, 0, 0, "R7 left truncate logical");
    apply(1, 40'hFF_0000_0001, 1, 0, 8'd8,   0, 0, 0, 0, 0, "R7 left truncate arith");
    apply(0, 40'h12_3456_789A, 1, 0, 8'hF0,  0, 0, 0, 0, 0, "R2 hold idle");
    apply(1, 40'hFF_FFFF_FFFF, 0, 0, 8'hD8,  0, 0, 0, 0, 0, "R8 R10 logical far right");
    apply(1, 40'h80_0000_0000, 1, 0, 8'hD8,  0, 0, 0, 0, 0, "R8 arith far right");
    apply(1, 40'h40_0000_0000, 1, 0, 8'h80,  0, 0, 0, 0, 0, "R8 imm -128");
    apply(1, 40'hFF_FFFF_FFFF, 1, 1, 8'h00,  0, 16'h8000, 0, 0, 0, "R8 reg -32768 left");
    apply(1, 40'h00_0000_0001, 0, 0, 8'd39,  0, 0, 0, 0, 0, "R7 R10 left 39");
    apply(1, 40'hA5_5A5A_A55A, 1, 0, 8'h00,  0, 0, 0, 0, 0, "R11 imm zero");
    apply(1, 40'h5A_A5A5_5AA5, 1, 1, 8'h00,  2, 0, 0, 16'h0000, 0, "R11 reg zero");
    apply(1, 40'h00_0000_0000, 1, 0, 8'd3,   0, 0, 0, 0, 0, "R10 zero result");
    for (int i = 0; i < 400; i++) begin
      logic [7:0] imm;
      logic [15:0] r;
      imm = ($urandom % 2) ? 8'($urandom) : 8'(($urandom % 97) - 48);
      r = ($urandom % 2) ? 16'($urandom) : 16'(($urandom % 97) - 48);
      apply(1'($urandom % 4 != 0), {8'($urandom), 32'($urandom)}, 1'($urandom),
            1'($urandom), imm, 2'($urandom), r, r ^ 16'h0003, -r, r >> 1, "R9 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule